// File: doc/BRIEF.md
# Floating-Point NaN Result Override Stage

This stage sits behind a floating-point datapath and makes its results bit-exact in the cases where IEEE-754 leaves the NaN encoding to the implementation. Each cycle it takes an operation class, a precision select, the two raw operand words and the raw word and invalid-operation flag from an upstream arithmetic core. It then forwards the upstream word unchanged or puts a defined word in its place. It computes no arithmetic of its own. It only selects, reshapes or substitutes words.

A NaN operand of a binary operation is propagated with its payload kept and its sign cleared, and operand A wins over operand B. Operations that create a NaN from non-NaN operands return a fixed canonical pattern. Conversions return fixed words on NaN input. Negation always flips the sign and nothing else. The result is registered, so it appears one cycle after its input strobe.

Operation class encoding on `in_op`: 0 = pass-through (compares and all others), 1 = binary arithmetic (add, subtract, multiply, divide, remainder), 2 = negate, 3 = float-to-integer/long, 4 = single-to-double, 5 = double-to-single. `in_dbl` = 1 selects double precision. A single-precision word occupies bits 31..0: sign at bit 31, exponent 30..23, fraction 22..0. A double word has sign at bit 63, exponent 62..52 and fraction 51..0. A NaN is an all-ones exponent with a nonzero fraction.

Top module: `fpx_nan_fixup`

## Requirements
- R1: For binary arithmetic with operand A a NaN (in the selected precision), the result is A with its sign bit cleared and every other bit kept, whether or not B is also a NaN. For single precision, bits 63..32 of the result are zero.
- R2: For binary arithmetic with A not a NaN and B a NaN, the result is B with its sign bit cleared (bits 63..32 zero in single precision).
- R3: For binary arithmetic with neither operand a NaN and `up_invalid` = 1, the result is 0x00000000_7FFF0000 in single precision and 0x7FFFE000_00000000 in double precision.
- R4: When no override case applies, including the pass-through class with NaN operands, `out_word` equals `up_word` exactly.
- R5: For float-to-integer/long with a NaN input of the selected precision, the result is all zeros.
- R6: For single-to-double with a single NaN in A[31:0], the result has sign 0, exponent 0x7FF, the 23 input fraction bits in result bits 51..29 and zeros in bits 28..0.
- R7: For double-to-single with a double NaN in A, the result is 0x00000000_7FFF0000.
- R8: Negate returns A with the sign bit of the selected precision inverted for any value, NaNs, infinities and zeros included. Bits 63..32 are zero in single precision.
- R9: An infinity (all-ones exponent, zero fraction) never triggers a NaN override.
- R10: `out_valid` equals the previous cycle's `in_valid`, and `out_word` is the result for the inputs of that cycle. A synchronous active-low reset clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input strobe |
| in_op | input | 3 | Operation class |
| in_dbl | input | 1 | 1 = double precision |
| in_a | input | 64 | Operand A word |
| in_b | input | 64 | Operand B word |
| up_word | input | 64 | Raw result from upstream core |
| up_invalid | input | 1 | Upstream operation produced a NaN |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_word | output | 64 | Final result word |

## Verification
The bench builds the stage with its default IEEE formats: an 8/23 single and an 11/52 double, with the canonical invalid patterns as given and the data register left unreset. With these values the bench can drive quiet and signalling NaNs with either sign and infinities of both signs. It also covers A/B priority when both operands are NaN, and the fraction widening from 23 to 52 bits, with every expected word worked out by hand.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
   typedef enum logic [2:0] {
      FPX_PASS  = 3'd0,
      FPX_ARITH = 3'd1,
      FPX_NEG   = 3'd2,
      FPX_TOINT = 3'd3,
      FPX_S2D   = 3'd4,
      FPX_D2S   = 3'd5
   } fpx_op_e;
endpackage

// File: rtl/fpx_nan_detect.sv
module fpx_nan_detect #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int W     = 1 + EXP_W + FRAC_W
) (
   input  logic [W-1:0] word,
   output logic         is_nan
);
   logic exp_ones;
   logic frac_nz;

   always_comb begin
      exp_ones = &word[W-2:FRAC_W];
      frac_nz  = |word[FRAC_W-1:0];
      is_nan   = exp_ones && frac_nz;
   end
endmodule

// File: rtl/fpx_fix_select.sv
module fpx_fix_select
   import fpx_pkg::*;
#(
   parameter int SP_EXP_W  = 8,
   parameter int SP_FRAC_W = 23,
   parameter int DP_EXP_W  = 11,
   parameter int DP_FRAC_W = 52,
   localparam int SP_W     = 1 + SP_EXP_W + SP_FRAC_W,
   localparam int DP_W     = 1 + DP_EXP_W + DP_FRAC_W,
   parameter logic [SP_W-1:0] SP_INAN = 32'h7FFF_0000,
   parameter logic [DP_W-1:0] DP_INAN = 64'h7FFF_E000_0000_0000
) (
   input  fpx_op_e         op,
   input  logic            dbl,
   input  logic [DP_W-1:0] a,
   input  logic [DP_W-1:0] b,
   input  logic [DP_W-1:0] up_word,
   input  logic            up_invalid,
   input  logic            a_sp_nan,
   input  logic            a_dp_nan,
   input  logic            b_sp_nan,
   input  logic            b_dp_nan,
   output logic [DP_W-1:0] fixed
);
   localparam int HI_W  = DP_W - SP_W;
   localparam int PAD_W = DP_FRAC_W - SP_FRAC_W;

   logic            a_nan, b_nan;
   logic [DP_W-1:0] a_clr, b_clr, a_neg, s2d_word, inan;

   always_comb begin
      a_nan = dbl ? a_dp_nan : a_sp_nan;
      b_nan = dbl ? b_dp_nan : b_sp_nan;
      a_clr = dbl ? {1'b0, a[DP_W-2:0]} : {{HI_W{1'b0}}, 1'b0, a[SP_W-2:0]};
      b_clr = dbl ? {1'b0, b[DP_W-2:0]} : {{HI_W{1'b0}}, 1'b0, b[SP_W-2:0]};
      a_neg = dbl ? {~a[DP_W-1], a[DP_W-2:0]}
                  : {{HI_W{1'b0}}, ~a[SP_W-1], a[SP_W-2:0]};
      s2d_word = {1'b0, {DP_EXP_W{1'b1}}, a[SP_FRAC_W-1:0], {PAD_W{1'b0}}};
      inan  = dbl ? DP_INAN : {{HI_W{1'b0}}, SP_INAN};

      unique case (op)
         FPX_ARITH: begin
            if (a_nan)           fixed = a_clr;
            else if (b_nan)      fixed = b_clr;
            else if (up_invalid) fixed = inan;
            else                 fixed = up_word;
         end
         FPX_NEG:   fixed = a_neg;
         FPX_TOINT: fixed = a_nan ? '0 : up_word;
         FPX_S2D:   fixed = a_sp_nan ? s2d_word : up_word;
         FPX_D2S:   fixed = a_dp_nan ? {{HI_W{1'b0}}, SP_INAN} : up_word;
         default:   fixed = up_word;
      endcase
   end
endmodule

// File: rtl/fpx_nan_fixup.sv
module fpx_nan_fixup
   import fpx_pkg::*;
#(
   parameter int SP_EXP_W  = 8,
   parameter int SP_FRAC_W = 23,
   parameter int DP_EXP_W  = 11,
   parameter int DP_FRAC_W = 52,
   parameter bit RESET_DATA = 1'b0,
   localparam int SP_W     = 1 + SP_EXP_W + SP_FRAC_W,
   localparam int DP_W     = 1 + DP_EXP_W + DP_FRAC_W,
   parameter logic [SP_W-1:0] SP_INAN = 32'h7FFF_0000,
   parameter logic [DP_W-1:0] DP_INAN = 64'h7FFF_E000_0000_0000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [2:0]      in_op,
   input  logic            in_dbl,
   input  logic [DP_W-1:0] in_a,
   input  logic [DP_W-1:0] in_b,
   input  logic [DP_W-1:0] up_word,
   input  logic            up_invalid,
   output logic            out_valid,
   output logic [DP_W-1:0] out_word
);
   generate
      if (DP_FRAC_W <= SP_FRAC_W) begin : g_bad_frac
         $error("double fraction must be wider than single fraction");
      end
      if (DP_EXP_W < SP_EXP_W) begin : g_bad_exp
         $error("double exponent must not be narrower than single exponent");
      end
   endgenerate

   fpx_op_e         op;
   logic [DP_W-1:0] opnd [2];
   logic [1:0]      sp_nan, dp_nan;
   logic [DP_W-1:0] fixed;

   assign op      = fpx_op_e'(in_op);
   assign opnd[0] = in_a;
   assign opnd[1] = in_b;

   for (genvar i = 0; i < 2; i++) begin : g_det
      fpx_nan_detect #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) u_sp (
         .word(opnd[i][SP_W-1:0]), .is_nan(sp_nan[i]));
      fpx_nan_detect #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W)) u_dp (
         .word(opnd[i]), .is_nan(dp_nan[i]));
   end

   fpx_fix_select #(
      .SP_EXP_W(SP_EXP_W), .SP_FRAC_W(SP_FRAC_W),
      .DP_EXP_W(DP_EXP_W), .DP_FRAC_W(DP_FRAC_W),
      .SP_INAN(SP_INAN), .DP_INAN(DP_INAN)
   ) u_sel (
      .op(op), .dbl(in_dbl), .a(in_a), .b(in_b),
      .up_word(up_word), .up_invalid(up_invalid),
      .a_sp_nan(sp_nan[0]), .a_dp_nan(dp_nan[0]),
      .b_sp_nan(sp_nan[1]), .b_dp_nan(dp_nan[1]),
      .fixed(fixed)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= in_valid;
   end

   generate
      if (RESET_DATA) begin : g_rst_data
         always_ff @(posedge clk) begin
            if (!rst_n)        out_word <= '0;
            else if (in_valid) out_word <= fixed;
         end
      end else begin : g_keep_data
         always_ff @(posedge clk) begin
            if (in_valid) out_word <= fixed;
         end
      end
   endgenerate

   // Assertions
   logic a_sp_inf;
   assign a_sp_inf = (&in_a[SP_W-2:SP_FRAC_W]) && !(|in_a[SP_FRAC_W-1:0]);

   a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r10_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r1_a_sign_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == FPX_ARITH && in_dbl && dp_nan[0])
      |=> (out_word[DP_W-1] == 1'b0 && out_word[DP_W-2:0] == $past(in_a[DP_W-2:0])));
   a_r5_toint_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == FPX_TOINT && !in_dbl && sp_nan[0]) |=> out_word == '0);
   a_r7_d2s_inan: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == FPX_D2S && dp_nan[0]) |=> out_word == {{(DP_W-SP_W){1'b0}}, SP_INAN});
   a_r8_neg_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == FPX_NEG && !in_dbl) |=> out_word[SP_W-1] != $past(in_a[SP_W-1]));
   a_r9_inf_passes: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == FPX_TOINT && !in_dbl && a_sp_inf) |=> out_word == $past(up_word));
endmodule

// File: tb/fpx_nan_fixup_tb.sv
module fpx_nan_fixup_tb;
   typedef struct packed {
      logic [23:0] tag;
      logic [2:0]  op;
      logic        dbl;
      logic [63:0] a;
      logic [63:0] b;
      logic [63:0] up;
      logic        inv;
      logic [63:0] exp;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VECS [NV] = '{
      '{"R1 ", 3'd1, 1'b0, 64'h0000_0000_FFC0_1234, 64'h0000_0000_7F80_0001, 64'h0000_0000_1234_5678, 1'b1, 64'h0000_0000_7FC0_1234},
      '{"R1 ", 3'd1, 1'b1, 64'hFFF8_0000_0000_ABCD, 64'h0, 64'h1, 1'b1, 64'h7FF8_0000_0000_ABCD},
      '{"R2 ", 3'd1, 1'b0, 64'h0000_0000_3F80_0000, 64'h0000_0000_FF80_0005, 64'h0, 1'b0, 64'h0000_0000_7F80_0005},
      '{"R2 ", 3'd1, 1'b1, 64'h0, 64'hFFF0_0000_0000_0001, 64'h5, 1'b1, 64'h7FF0_0000_0000_0001},
      '{"R3 ", 3'd1, 1'b0, 64'h0000_0000_7F80_0000, 64'h0000_0000_FF80_0000, 64'h0000_0000_7FC0_0000, 1'b1, 64'h0000_0000_7FFF_0000},
      '{"R3 ", 3'd1, 1'b1, 64'h0, 64'h0, 64'h7FF8_0000_0000_0000, 1'b1, 64'h7FFF_E000_0000_0000},
      '{"R4 ", 3'd1, 1'b0, 64'h0000_0000_3F80_0000, 64'h0000_0000_4000_0000, 64'h0000_0000_4040_0000, 1'b0, 64'h0000_0000_4040_0000},
      '{"R4 ", 3'd0, 1'b0, 64'h0000_0000_7FC0_0000, 64'h0000_0000_7FC0_0000, 64'h1, 1'b1, 64'h1},
      '{"R5 ", 3'd3, 1'b0, 64'h0000_0000_7FC0_0001, 64'h0, 64'h0000_0000_DEAD_BEEF, 1'b0, 64'h0},
      '{"R5 ", 3'd3, 1'b1, 64'hFFF0_0000_0000_0002, 64'h0, 64'h123, 1'b0, 64'h0},
      '{"R9 ", 3'd3, 1'b0, 64'h0000_0000_7F80_0000, 64'h0, 64'h0000_0000_7FFF_FFFF, 1'b0, 64'h0000_0000_7FFF_FFFF},
      '{"R6 ", 3'd4, 1'b0, 64'h0000_0000_FFC0_0003, 64'h0, 64'h9, 1'b0, 64'h7FF8_0000_6000_0000},
      '{"R6 ", 3'd4, 1'b0, 64'h0000_0000_3F80_0000, 64'h0, 64'h3FF0_0000_0000_0000, 1'b0, 64'h3FF0_0000_0000_0000},
      '{"R7 ", 3'd5, 1'b1, 64'hFFF0_0000_0000_0010, 64'h0, 64'h5, 1'b0, 64'h0000_0000_7FFF_0000},
      '{"R9 ", 3'd5, 1'b1, 64'h7FF0_0000_0000_0000, 64'h0, 64'h0000_0000_7F80_0000, 1'b0, 64'h0000_0000_7F80_0000},
      '{"R8 ", 3'd2, 1'b0, 64'h0000_0000_7FC0_0000, 64'h0, 64'h77, 1'b0, 64'h0000_0000_FFC0_0000},
      '{"R8 ", 3'd2, 1'b1, 64'h0, 64'h0, 64'h77, 1'b0, 64'h8000_0000_0000_0000},
      '{"R8 ", 3'd2, 1'b0, 64'h0000_0000_FF80_0000, 64'h0, 64'h77, 1'b0, 64'h0000_0000_7F80_0000},
      '{"R9 ", 3'd1, 1'b0, 64'h0000_0000_7F80_0000, 64'h0000_0000_7F80_0000, 64'h0000_0000_7F80_0000, 1'b0, 64'h0000_0000_7F80_0000},
      '{"R1 ", 3'd1, 1'b1, 64'hFFF0_0000_0000_0007, 64'h7FF8_0000_0000_0001, 64'h0, 1'b0, 64'h7FF0_0000_0000_0007}
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [2:0]  in_op;
   logic        in_dbl;
   logic [63:0] in_a, in_b, up_word;
   logic        up_invalid;
   logic        out_valid;
   logic [63:0] out_word;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   fpx_nan_fixup u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_dbl(in_dbl), .in_a(in_a), .in_b(in_b), .up_word(up_word),
      .up_invalid(up_invalid), .out_valid(out_valid), .out_word(out_word)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_dbl = 1'b0;
      in_a = '0; in_b = '0; up_word = '0; up_invalid = 1'b0;
      repeat (3) @(negedge clk);
      check("R10 reset valid", {63'b0, out_valid}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         in_valid = 1'b1;
         in_op = VECS[i].op; in_dbl = VECS[i].dbl;
         in_a = VECS[i].a; in_b = VECS[i].b;
         up_word = VECS[i].up; up_invalid = VECS[i].inv;
         @(negedge clk);
         check("R10 valid", {63'b0, out_valid}, 64'h1);
         check(string'(VECS[i].tag), out_word, VECS[i].exp);
      end

      // R10: valid drops one cycle after in_valid drops
      in_valid = 1'b0;
      @(negedge clk);
      check("R10 idle", {63'b0, out_valid}, 64'h0);

      // R10: back-to-back with latency of one cycle (R4 pass-through)
      in_valid = 1'b1; in_op = 3'd0; up_word = 64'hAAAA_5555_0000_FFFF;
      @(negedge clk);
      in_op = 3'd2; in_dbl = 1'b1; in_a = 64'h8000_0000_0000_0001;
      check("R4 back-to-back", out_word, 64'hAAAA_5555_0000_FFFF);
      @(negedge clk);
      check("R8 back-to-back", out_word, 64'h0000_0000_0000_0001);

      // R10: reset with in_valid high clears out_valid
      rst_n = 1'b0;
      @(negedge clk);
      check("R10 reset while busy", {63'b0, out_valid}, 64'h0);
      rst_n = 1'b1; in_valid = 1'b0;
      @(negedge clk);
      check("R10 after reset", {63'b0, out_valid}, 64'h0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule